// File: doc/BRIEF.md
# Configuration Image Streaming Engine

This block moves a partial configuration image from system memory into a 32-bit configuration port. A recovery controller, or software, gives it a start word address, a word count and a one-cycle start pulse. The engine then issues single-word reads on a bus-master read port and buffers the returned data in a 16-entry FIFO. It writes one word per clock into the configuration port whenever the FIFO holds data.

The memory may grant requests late and may return data after any number of cycles, but it returns the data in request order. The engine issues a read only when the FIFO has room for it, counting both the words already buffered and the reads still in flight. The FIFO therefore never overflows, and read latency does not cause writes to be dropped or repeated.

When the last word has been written, the engine raises a one-cycle done pulse. The recovery logic uses this pulse to lift the processor pipeline freeze. A count of zero produces done straight away, with no traffic.

Top module: `cfg_stream_engine`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o and cfg_we_o are all low.
- R2: A start_i pulse with a nonzero word_count_i while idle sets busy_o in the next cycle. The engine then issues exactly word_count_i read requests, at word addresses start_addr_i, start_addr_i+1, and so on in increasing order, with one word per request.
- R3: The number of words held in the FIFO plus the number of reads granted but not yet returned never exceeds 16. A long-latency memory drives this total up to 16.
- R4: A read request that is not granted stays asserted in the next cycle, with the same address.
- R5: cfg_we_o is high only when the FIFO is non-empty. cfg_data_o carries the memory words in address order, with none lost and none repeated, and there are no writes while the engine is idle.
- R6: When the memory grants every request and returns each word after a fixed two-cycle latency, the writes occupy consecutive clock cycles, one word per clock.
- R7: done_o is high for exactly one cycle, in the cycle after the last cfg_we_o cycle, and busy_o is low in that cycle.
- R8: A start_i pulse with word_count_i equal to 0 while idle raises done_o in the next cycle. busy_o stays low and no read or write takes place.
- R9: A start_i pulse while busy_o is high is ignored: it adds no reads, no writes and no second done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a transfer |
| start_addr_i | input | 32 | First word address of the image |
| word_count_i | input | 16 | Number of 32-bit words to move |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Read request to memory |
| mem_addr_o | output | 32 | Word address of the request |
| mem_gnt_i | input | 1 | Memory accepts the request in this cycle |
| mem_rvalid_i | input | 1 | Read data valid, in request order |
| mem_rdata_i | input | 32 | Read data |
| cfg_we_o | output | 1 | Configuration port write strobe |
| cfg_data_o | output | 32 | Configuration port write data |

## Verification
The bound checker enforces several rules on every cycle:
- the credit bound of buffered words plus in-flight reads;
- a held request keeping its address;
- a write only when the FIFO is non-empty;
- the single-cycle done pulse and its exclusion with busy;
- the immediate done for a zero count;
- a step of one word between granted addresses;
- no traffic while idle.

Some properties span a whole transfer, and only the bench scenarios can show them. These are exact data order with no loss or duplication, the request count, back-to-back full-rate writes under a fixed latency, the FIFO filling to its credit limit under a long latency, and a start pulse issued mid-transfer leaving no trace.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} eng_state_e;

  function automatic int unsigned ptr_width(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cfg_sync_fifo.sv
module cfg_sync_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = cfg_stream_pkg::ptr_width(DEPTH),
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [OCC_W-1:0]  count_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [OCC_W-1:0]  count_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[i] <= '0;
      else if (push_i && wr_ptr_q == PTR_W'(i)) slot_q[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + OCC_W'(1);
        2'b01:   count_q <= count_q - OCC_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign dout_o  = slot_q[rd_ptr_q];
  assign count_o = count_q;
  assign empty_o = (count_q == '0);
endmodule

// File: rtl/cfg_fetch_ctrl.sv
module cfg_fetch_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1),
  localparam int unsigned RES_W = OCC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic              gnt_i,
  input  logic              rvalid_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OCC_W-1:0]  inflight_o
);
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  logic [OCC_W-1:0]  inflight_q;
  logic [RES_W-1:0]  reserved;
  logic              accept;

  // credit: buffered words plus reads still owed by memory
  assign reserved = {1'b0, occ_i} + {1'b0, inflight_q};
  assign req_o    = (left_q != '0) && (reserved < RES_W'(DEPTH));
  assign accept   = req_o && gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q     <= '0;
      addr_q     <= '0;
      inflight_q <= '0;
    end else begin
      if (launch_i) begin
        left_q <= len_i;
        addr_q <= base_i;
      end else if (accept) begin
        left_q <= left_q - CNT_W'(1);
        addr_q <= addr_q + ADDR_W'(1);
      end
      case ({accept, rvalid_i})
        2'b10:   inflight_q <= inflight_q + OCC_W'(1);
        2'b01:   inflight_q <= inflight_q - OCC_W'(1);
        default: inflight_q <= inflight_q;
      endcase
    end
  end

  assign addr_o     = addr_q;
  assign inflight_o = inflight_q;
endmodule

// File: rtl/cfg_port_writer.sv
module cfg_port_writer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             empty_i,
  output logic             we_o,
  output logic             last_o
);
  logic [CNT_W-1:0] left_q;

  assign we_o   = (left_q != '0) && !empty_i;
  assign last_o = we_o && (left_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       left_q <= '0;
    else if (launch_i) left_q <= len_i;
    else if (we_o)     left_q <= left_q - CNT_W'(1);
  end
endmodule

// File: rtl/cfg_stream_engine.sv
module cfg_stream_engine #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  word_count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              cfg_we_o,
  output logic [DATA_W-1:0] cfg_data_o
);
  import cfg_stream_pkg::*;

  eng_state_e       state_q;
  logic             done_q;
  logic             take, launch, last_wr, fifo_empty;
  logic [OCC_W-1:0] fifo_count, inflight;

  assign take   = start_i && (state_q == ST_IDLE);
  assign launch = take && (word_count_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= (take && word_count_i == '0) || last_wr;
      if (launch)       state_q <= ST_RUN;
      else if (last_wr) state_q <= ST_IDLE;
    end
  end

  cfg_fetch_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_fetch (
    .clk_i, .rst_ni,
    .launch_i  (launch),
    .base_i    (start_addr_i),
    .len_i     (word_count_i),
    .occ_i     (fifo_count),
    .gnt_i     (mem_gnt_i),
    .rvalid_i  (mem_rvalid_i),
    .req_o     (mem_req_o),
    .addr_o    (mem_addr_o),
    .inflight_o(inflight)
  );

  cfg_sync_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (mem_rvalid_i),
    .din_i  (mem_rdata_i),
    .pop_i  (cfg_we_o),
    .dout_o (cfg_data_o),
    .count_o(fifo_count),
    .empty_o(fifo_empty)
  );

  cfg_port_writer #(.CNT_W(CNT_W)) u_writer (
    .clk_i, .rst_ni,
    .launch_i(launch),
    .len_i   (word_count_i),
    .empty_i (fifo_empty),
    .we_o    (cfg_we_o),
    .last_o  (last_wr)
  );

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/cfg_stream_engine_chk.sv
module cfg_stream_engine_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned OCC_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  word_count_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              cfg_we_o,
  input logic [OCC_W-1:0]  fifo_count,
  input logic [OCC_W-1:0]  inflight
);
  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o || mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, fifo_count} + {1'b0, inflight}) <= (OCC_W + 1)'(DEPTH));

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  assert_we_nonempty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> fifo_count != '0);

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !cfg_we_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_zero_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && word_count_i == '0 |=> done_o && !busy_o);
endmodule

bind cfg_stream_engine cfg_stream_engine_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .word_count_i(word_count_i),
  .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i),
  .mem_addr_o(mem_addr_o), .cfg_we_o(cfg_we_o), .fifo_count(fifo_count),
  .inflight(inflight)
);

// File: tb/sim_cfg_stream_engine.sv
`timescale 1ns/1ps
module sim_cfg_stream_engine;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic [15:0] word_count_i = '0;
  logic        busy_o, done_o, mem_req_o, cfg_we_o;
  logic [31:0] mem_addr_o, cfg_data_o;
  logic        mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  cfg_stream_engine u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  // memory model state
  bit          gnt_always = 1, var_lat = 0;
  int          fixed_lat = 2;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] acc_addr_q[$];
  int          acc_due_q[$];
  int          last_due = 0, acc_total = 0, wr_total = 0, peak_res = 0;
  int          req_seen = 0;
  logic [31:0] exp_req_addr = '0;
  bit          prev_stall = 0;
  logic [31:0] prev_addr = '0;

  // scoreboard state
  logic [31:0] exp_q[$];
  int          done_cnt = 0, first_we = -1, last_we = -1;
  bit          nonzero = 0;

  function automatic logic [31:0] word_of(logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    int res, lat, due;
    bit g;
    cyc++;
    if (rst_ni) begin
      // R3 credit bound seen from the ports
      res = acc_total - wr_total;
      if (res > peak_res) peak_res = res;
      if (res > 16) chk(0, "R3", "buffered+inflight", res, 16);
      // R4 held request
      if (prev_stall) begin
        chk(mem_req_o && mem_addr_o == prev_addr, "R4", "held request addr", mem_addr_o, prev_addr);
      end
      // monitor: configuration port
      if (cfg_we_o) begin
        wr_total++;
        if (first_we < 0) first_we = cyc;
        last_we = cyc;
        if (exp_q.size() == 0) chk(0, "R5", "unexpected write", cfg_data_o, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(cfg_data_o == e, "R5", "write data", cfg_data_o, e);
        end
      end
      if (done_o) begin
        done_cnt++;
        chk(exp_q.size() == 0, "R7", "words left at done", exp_q.size(), 0);
        chk(!busy_o, "R7", "busy during done", busy_o, 0);
        if (nonzero) chk(last_we == cyc - 1, "R7", "done after last write", last_we, cyc - 1);
      end
      // memory response
      mem_rvalid_i = 1'b0;
      if (acc_due_q.size() != 0 && acc_due_q[0] <= cyc) begin
        void'(acc_due_q.pop_front());
        mem_rdata_i  = word_of(acc_addr_q.pop_front());
        mem_rvalid_i = 1'b1;
      end
      // grant decision for the coming edge
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      g = gnt_always ? 1'b1 : (lfsr[0] | lfsr[3]);
      mem_gnt_i = g;
      prev_stall = mem_req_o && !g;
      prev_addr  = mem_addr_o;
      if (mem_req_o && g) begin
        chk(mem_addr_o == exp_req_addr, "R2", "request addr", mem_addr_o, exp_req_addr);
        exp_req_addr++;
        req_seen++;
        acc_total++;
        lat = var_lat ? 1 + int'(lfsr[6:4]) : fixed_lat;
        due = cyc + lat;
        if (due <= last_due) due = last_due + 1;
        last_due = due;
        acc_addr_q.push_back(mem_addr_o);
        acc_due_q.push_back(due);
      end
    end
  end

  task automatic run_xfer(logic [31:0] a, int n, bit poke);
    int d0, r0;
    exp_req_addr = a;
    for (int i = 0; i < n; i++) exp_q.push_back(word_of(a + 32'(i)));
    nonzero = (n != 0);
    first_we = -1;
    d0 = done_cnt;
    r0 = req_seen;
    start_addr_i = a;
    word_count_i = 16'(n);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (n == 0) begin
      chk(done_o == 1'b1, "R8", "immediate done", done_o, 1);
      chk(busy_o == 1'b0, "R8", "busy on zero count", busy_o, 0);
      repeat (5) @(negedge clk_i);
      chk(req_seen == r0, "R8", "reads on zero count", req_seen - r0, 0);
      chk(done_cnt == d0 + 1, "R8", "done count", done_cnt - d0, 1);
      return;
    end
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    if (poke) begin
      repeat (6) @(negedge clk_i);
      start_addr_i = 32'h900;
      word_count_i = 16'd5;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk_i);
    chk(req_seen - r0 == n, "R2", "request count", req_seen - r0, n);
    if (!var_lat && gnt_always && fixed_lat == 2)
      chk(last_we - first_we == n - 1, "R6", "write span", last_we - first_we, n - 1);
    repeat (20) @(negedge clk_i);
    if (poke) begin
      chk(done_cnt == d0 + 1, "R9", "done pulses", done_cnt - d0, 1);
      chk(req_seen - r0 == n, "R9", "reads after ignored start", req_seen - r0, n);
    end
    chk(exp_q.size() == 0, "R5", "words missing", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !cfg_we_o, "R1", "reset outputs",
        {busy_o, done_o, mem_req_o, cfg_we_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !cfg_we_o, "R1", "idle after reset",
        {busy_o, done_o, mem_req_o, cfg_we_o}, 0);

    gnt_always = 1; var_lat = 0; fixed_lat = 2;
    run_xfer(32'h100, 40, 0);               // R2 R5 R6 R7

    gnt_always = 0; var_lat = 1;
    run_xfer(32'h2000, 37, 1);              // R4 R5 R9

    gnt_always = 1; var_lat = 0; fixed_lat = 40;
    peak_res = 0;
    run_xfer(32'h40, 50, 0);
    chk(peak_res == 16, "R3", "credit peak", peak_res, 16);

    fixed_lat = 2;
    run_xfer(32'h7000, 0, 0);               // R8
    run_xfer(32'h55, 1, 0);                 // single word
    gnt_always = 0; var_lat = 1;
    run_xfer(32'h1234, 16, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule